// File: doc/BRIEF.md
# Early-Terminating Sequential Integer Divider

This block divides one 32-bit integer by another, either as two's-complement signed values or as unsigned values, and retires one quotient bit per clock using a shift-and-subtract step. Before the first step it finds how many 8-bit chunks of the dividend's magnitude hold significant bits. It aligns the top significant chunk with the top of the working register and runs only as many steps as those chunks need. Short dividends therefore finish sooner, and there are four distinct completion times.

A caller pulses `start` with the operands and the `is_signed` select. `busy` then stays high while the division runs, and `done` pulses for one cycle when the results appear. The quotient goes to the `lo` register and the remainder to the `hi` register. Both registers keep their values until the next division completes. A new division may be launched in the same cycle that `done` is high. A zero divisor produces an unspecified result in the normal number of cycles.

Top module: `seq_divider`

## Requirements
- R1: Count the cycle in which `start` is accepted as cycle 1. Then `done` is high in cycle 12, 19, 26 or 33 when the dividend's magnitude needs 1, 2, 3 or 4 significant 8-bit chunks. A zero dividend counts as one chunk.
- R2: The chunk count comes from the dividend alone. In signed mode it is taken from the two's-complement magnitude, so -128 counts as one chunk. `busy` is high from the cycle after acceptance up to the cycle before `done`, and it is low while `done` is high.
- R3: In unsigned mode, `lo` holds the truncated quotient and `hi` holds the remainder, with dividend = quotient × divisor + remainder and remainder < divisor.
- R4: In signed mode, the quotient is rounded toward zero. The remainder takes the sign of the dividend, or is zero, and its magnitude is below the divisor's magnitude.
- R5: A `start` pulse that arrives while `busy` is high is ignored. It changes neither the completion cycle nor the results of the division in flight.
- R6: A `start` pulse in the cycle where `done` is high is accepted. Successive launches can therefore be spaced 11, 18, 25 or 32 cycles apart for 1 to 4 chunks.
- R7: `done` is high for exactly one cycle per division. `lo` and `hi` change only on the edge that raises `done`, and they hold their values otherwise.
- R8: A zero divisor still completes at the cycle given by R1, and the block accepts a new start afterwards.
- R9: After synchronous reset, `busy` and `done` are low and `lo` and `hi` are zero.
- R10: Signed division of -2147483648 by -1 completes in 33 cycles with `lo` = 0x80000000 and `hi` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch strobe; accepted only when not busy |
| is_signed | input | 1 | 1 selects two's-complement division, 0 selects unsigned |
| dividend | input | 32 | Dividend, sampled on the accepting edge |
| divisor | input | 32 | Divisor, sampled on the accepting edge |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse when results are written |
| lo | output | 32 | Quotient register |
| hi | output | 32 | Remainder register |

## Verification
The bench targets chunk-boundary dividends in each of the four size classes. If the size detection were off by one chunk, the division would finish seven cycles early or late, and a wrong alignment shift would give a garbage quotient. Signed cases cover every sign pairing, the -128 magnitude and the most negative dividend. They expose a sign fix-up that was inverted or applied to the wrong result, and a size taken from the raw bit pattern instead of the magnitude (an 8-bit negative would then take 33 cycles). A start pulse injected mid-run and a relaunch in the `done` cycle show whether busy gating is missing (the results would be overwritten) or too strict (the relaunch would be lost). A zero divisor confirms that the counter, not the data, ends the run.

// File: rtl/sd_pkg.sv
package sd_pkg;

  // Fixed overhead cycles added to the per-chunk cost in the busy budget.
  localparam int SD_FIX_CYC = 4;

  // Cycles between acceptance and the next possible acceptance.
  function automatic int sd_budget(input int chunk, input int nchunks);
    return (chunk - 1) * nchunks + SD_FIX_CYC;
  endfunction

  typedef struct packed {
    logic q_neg;
    logic r_neg;
  } sd_sign_t;

endpackage

// File: rtl/sd_size_detect.sv
module sd_size_detect #(
  parameter int WIDTH = 32,
  parameter int CHUNK = 8,
  localparam int NCHUNK = WIDTH / CHUNK,
  localparam int KW = $clog2(NCHUNK + 1)
) (
  input  logic [WIDTH-1:0] value,
  output logic [KW-1:0]    nchunks
);

  logic [NCHUNK-1:0] nz;

  for (genvar g = 0; g < NCHUNK; g++) begin : g_chunk
    assign nz[g] = |value[g*CHUNK +: CHUNK];
  end

  // Highest non-empty chunk wins; an all-zero value still costs one chunk.
  always_comb begin
    nchunks = KW'(1);
    for (int i = 0; i < NCHUNK; i++) begin
      if (nz[i]) nchunks = KW'(i + 1);
    end
  end

endmodule

// File: rtl/sd_step.sv
module sd_step #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] rem_i,
  input  logic [WIDTH-1:0] quo_i,
  input  logic [WIDTH-1:0] dvs_i,
  output logic [WIDTH-1:0] rem_o,
  output logic [WIDTH-1:0] quo_o
);

  logic [WIDTH:0] shifted;
  logic [WIDTH:0] diff;
  logic           fits;

  // Restoring step: pull the next dividend bit into the partial remainder.
  assign shifted = {rem_i, quo_i[WIDTH-1]};
  assign diff    = shifted - {1'b0, dvs_i};
  assign fits    = ~diff[WIDTH];
  assign rem_o   = fits ? diff[WIDTH-1:0] : shifted[WIDTH-1:0];
  assign quo_o   = {quo_i[WIDTH-2:0], fits};

endmodule

// File: rtl/sd_sign_fix.sv
module sd_sign_fix
  import sd_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  sd_sign_t         sign,
  input  logic [WIDTH-1:0] quo_mag,
  input  logic [WIDTH-1:0] rem_mag,
  output logic [WIDTH-1:0] quo,
  output logic [WIDTH-1:0] rem
);

  assign quo = sign.q_neg ? (~quo_mag + 1'b1) : quo_mag;
  assign rem = sign.r_neg ? (~rem_mag + 1'b1) : rem_mag;

endmodule

// File: rtl/seq_divider.sv
module seq_divider
  import sd_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int CHUNK = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             is_signed,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] lo,
  output logic [WIDTH-1:0] hi
);

  localparam int NCHUNK = WIDTH / CHUNK;
  localparam int KW     = $clog2(NCHUNK + 1);
  localparam int BITW   = $clog2(WIDTH + 1);
  localparam int MAXBUD = sd_budget(CHUNK, NCHUNK);
  localparam int CNTW   = $clog2(MAXBUD + 1);

  // Working state
  logic [WIDTH-1:0] rem_q, quo_q, dvs_q;
  logic [BITW-1:0]  left_q;
  logic [CNTW-1:0]  cnt_q;
  sd_sign_t         sign_q;

  // Operand preparation
  logic             a_neg, b_neg;
  logic [WIDTH-1:0] mag_a, mag_b, aligned;
  logic [KW-1:0]    nchunks;
  int               shamt;
  logic             accept;

  assign accept = start & ~busy;
  assign a_neg  = is_signed & dividend[WIDTH-1];
  assign b_neg  = is_signed & divisor[WIDTH-1];
  assign mag_a  = a_neg ? (~dividend + 1'b1) : dividend;
  assign mag_b  = b_neg ? (~divisor + 1'b1) : divisor;

  sd_size_detect #(.WIDTH(WIDTH), .CHUNK(CHUNK)) size_i (
    .value   (mag_a),
    .nchunks (nchunks)
  );

  assign shamt   = WIDTH - int'(nchunks) * CHUNK;
  assign aligned = mag_a << shamt;

  // Step input mux: the accepting edge already performs the first step.
  logic [WIDTH-1:0] in_rem, in_quo, in_dvs;
  logic [BITW-1:0]  in_left;
  logic             step_en;
  logic [WIDTH-1:0] rem_s, quo_s, rem_n, quo_n;
  logic [BITW-1:0]  left_n;

  assign in_rem  = accept ? '0      : rem_q;
  assign in_quo  = accept ? aligned : quo_q;
  assign in_dvs  = accept ? mag_b   : dvs_q;
  assign in_left = accept ? BITW'(int'(nchunks) * CHUNK) : left_q;
  assign step_en = (in_left != '0);

  sd_step #(.WIDTH(WIDTH)) step_i (
    .rem_i (in_rem),
    .quo_i (in_quo),
    .dvs_i (in_dvs),
    .rem_o (rem_s),
    .quo_o (quo_s)
  );

  assign rem_n  = step_en ? rem_s : in_rem;
  assign quo_n  = step_en ? quo_s : in_quo;
  assign left_n = step_en ? (in_left - 1'b1) : in_left;

  // Final sign correction on the values the last edge would store.
  logic [WIDTH-1:0] quo_fix, rem_fix;

  sd_sign_fix #(.WIDTH(WIDTH)) fix_i (
    .sign    (sign_q),
    .quo_mag (quo_n),
    .rem_mag (rem_n),
    .quo     (quo_fix),
    .rem     (rem_fix)
  );

  logic finish;
  assign finish = busy & (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      lo     <= '0;
      hi     <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      left_q <= '0;
      cnt_q  <= '0;
      sign_q <= '0;
    end else begin
      done <= finish;
      if (accept) begin
        busy         <= 1'b1;
        cnt_q        <= CNTW'(sd_budget(CHUNK, int'(nchunks)) - 2);
        rem_q        <= rem_n;
        quo_q        <= quo_n;
        dvs_q        <= in_dvs;
        left_q       <= left_n;
        sign_q.q_neg <= a_neg ^ b_neg;
        sign_q.r_neg <= a_neg;
      end else if (busy) begin
        rem_q  <= rem_n;
        quo_q  <= quo_n;
        left_q <= left_n;
        if (finish) begin
          busy <= 1'b0;
          lo   <= quo_fix;
          hi   <= rem_fix;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/seq_divider_chk.sv
module seq_divider_chk
  import sd_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int CHUNK = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] lo,
  input logic [WIDTH-1:0] hi
);

  localparam int MAXBUSY = sd_budget(CHUNK, WIDTH / CHUNK) - 1;

  logic [15:0] run;
  always_ff @(posedge clk) begin
    if (rst || !busy) run <= '0;
    else              run <= run + 1'b1;
  end

  // R7: done is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: results move only together with done
  a_r7_lo_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(lo) |-> done);
  a_r7_hi_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(hi) |-> done);

  // R2: busy is low in the done cycle
  a_r2_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R2: an accepted start raises busy
  a_r2_busy_after_start: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R2: busy does not rise without a start
  a_r2_no_spurious_busy: assert property (@(posedge clk) disable iff (rst)
    (!start && !busy) |=> !busy);

  // R8: no run outlasts the longest budget, whatever the divisor
  a_r8_busy_bounded: assert property (@(posedge clk) disable iff (rst)
    busy |-> (run < 16'(MAXBUSY)));

endmodule

bind seq_divider seq_divider_chk #(.WIDTH(WIDTH), .CHUNK(CHUNK)) chk_i (
  .clk   (clk),
  .rst   (rst),
  .start (start),
  .busy  (busy),
  .done  (done),
  .lo    (lo),
  .hi    (hi)
);

// File: tb/seq_divider_tb_top.sv
module seq_divider_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        is_signed = 1'b0;
  logic [31:0] dividend = '0;
  logic [31:0] divisor = '0;
  logic        busy, done;
  logic [31:0] lo, hi;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  seq_divider dut_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .is_signed (is_signed),
    .dividend  (dividend),
    .divisor   (divisor),
    .busy      (busy),
    .done      (done),
    .lo        (lo),
    .hi        (hi)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_lat(input logic [31:0] a, input bit s);
    logic [31:0] m;
    int k;
    m = (s && a[31]) ? (~a + 1) : a;
    if (m[31:24] != 0)      k = 4;
    else if (m[23:16] != 0) k = 3;
    else if (m[15:8] != 0)  k = 2;
    else                    k = 1;
    return 7 * k + 5;
  endfunction

  function automatic logic [31:0] exp_q(input logic [31:0] a, input logic [31:0] b, input bit s);
    if (s) return $signed(a) / $signed(b);
    return a / b;
  endfunction

  function automatic logic [31:0] exp_r(input logic [31:0] a, input logic [31:0] b, input bit s);
    if (s) return $signed(a) % $signed(b);
    return a % b;
  endfunction

  // Drive a start that is accepted on the next rising edge.
  task automatic launch(input logic [31:0] a, input logic [31:0] b, input bit s);
    start = 1'b1; dividend = a; divisor = b; is_signed = s;
    @(posedge clk);
    #1 start = 1'b0;
  endtask

  // Returns latency as cycle index of done (start cycle = 1).
  task automatic wait_done(output int lat);
    int n = 0;
    forever begin
      @(negedge clk);
      if (done || n > 60) break;
      n++;
    end
    lat = n + 2;
  endtask

  task automatic run_one(input logic [31:0] a, input logic [31:0] b, input bit s,
                         input string rl, input string rd);
    int lat;
    @(negedge clk);
    launch(a, b, s);
    wait_done(lat);
    check(lat == exp_lat(a, s), rl, lat, exp_lat(a, s));
    check(lo == exp_q(a, b, s), {rd, " quotient"}, lo, exp_q(a, b, s));
    check(hi == exp_r(a, b, s), {rd, " remainder"}, hi, exp_r(a, b, s));
  endtask

  task automatic t_reset;
    check(busy == 1'b0, "R9 busy", busy, 0);
    check(done == 1'b0, "R9 done", done, 0);
    check(lo == 32'd0, "R9 lo", lo, 0);
    check(hi == 32'd0, "R9 hi", hi, 0);
  endtask

  task automatic t_unsigned;
    run_one(32'd200, 32'd7, 1'b0, "R1 1-chunk latency", "R3");
    run_one(32'd50000, 32'd123, 1'b0, "R1 2-chunk latency", "R3");
    run_one(32'h00ABCDEF, 32'h1234, 1'b0, "R1 3-chunk latency", "R3");
    run_one(32'hFFFFFFFF, 32'd3, 1'b0, "R1 4-chunk latency", "R3");
    run_one(32'd0, 32'd9, 1'b0, "R1 zero dividend latency", "R3 zero");
    run_one(32'd255, 32'd256, 1'b0, "R1 chunk edge 255", "R3 divisor larger");
  endtask

  task automatic t_signed;
    run_one(-32'sd100, 32'sd7, 1'b1, "R2 signed magnitude", "R4 neg/pos");
    run_one(32'sd100, -32'sd7, 1'b1, "R2 signed magnitude", "R4 pos/neg");
    run_one(-32'sd100000, -32'sd37, 1'b1, "R2 signed magnitude", "R4 neg/neg");
    run_one(-32'sd128, 32'sd5, 1'b1, "R2 -128 one chunk", "R4 -128");
    run_one(-32'sd2147483647, 32'sd10, 1'b1, "R2 signed 4-chunk", "R4 large");
    // Same bit pattern unsigned takes the full four chunks.
    run_one(32'hFFFFFF9C, 32'd7, 1'b0, "R2 unsigned raw size", "R3 raw");
  endtask

  task automatic t_min_by_minus_one;
    int lat;
    @(negedge clk);
    launch(32'h80000000, 32'hFFFFFFFF, 1'b1);
    wait_done(lat);
    check(lat == 33, "R10 latency", lat, 33);
    check(lo == 32'h80000000, "R10 quotient", lo, 32'h80000000);
    check(hi == 32'd0, "R10 remainder", hi, 0);
  endtask

  task automatic t_divzero;
    int lat;
    @(negedge clk);
    launch(32'h00BC614E, 32'd0, 1'b0);
    wait_done(lat);
    check(lat == 26, "R8 zero divisor latency", lat, 26);
    run_one(32'd91, 32'd13, 1'b0, "R8 recovery latency", "R8 recovery");
  endtask

  task automatic t_busy_ignore;
    int n = 0;
    bit seen_idle = 1'b0;
    @(negedge clk);
    launch(32'd1000, 32'd3, 1'b0);
    repeat (3) @(negedge clk);
    start = 1'b1; dividend = 32'd77; divisor = 32'd15;
    @(negedge clk);
    start = 1'b0;
    // Started 4 negedges ago: n counts from the accept edge.
    n = 4;
    forever begin
      if (done || n > 60) break;
      if (!busy) seen_idle = 1'b1;
      @(negedge clk);
      n++;
    end
    check(n + 1 == 19, "R5 latency unchanged", n + 1, 19);
    check(!seen_idle, "R5 busy held", seen_idle, 0);
    check(lo == 32'd333, "R5 quotient kept", lo, 333);
    check(hi == 32'd1, "R5 remainder kept", hi, 1);
  endtask

  task automatic t_back_to_back;
    int lat;
    @(negedge clk);
    launch(32'd90, 32'd4, 1'b0);
    wait_done(lat);
    check(lat == 12, "R6 first latency", lat, 12);
    // Relaunch in the done cycle.
    launch(32'd60000, 32'd7, 1'b0);
    @(negedge clk);
    check(done == 1'b0, "R7 done one cycle", done, 0);
    check(busy == 1'b1, "R6 relaunch accepted", busy, 1);
    check(lo == 32'd22 && hi == 32'd2, "R7 results held", {lo, hi}, {32'd22, 32'd2});
    // One negedge already consumed after the accept edge.
    lat = 1;
    forever begin
      @(negedge clk);
      if (done || lat > 60) break;
      lat++;
    end
    check(lat + 2 == 19, "R6 repeat latency", lat + 2, 19);
    check(lo == 32'd8571, "R6 quotient", lo, 8571);
    check(hi == 32'd3, "R6 remainder", hi, 3);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL R8 watchdog expired actual=hung expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_unsigned();
    t_signed();
    t_min_by_minus_one();
    t_divzero();
    t_busy_ignore();
    t_back_to_back();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule